// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the control logic placed ahead of a successive-approximation converter in an eight-channel serial ADC. A host programs it through a plain register write/read strobe interface. The host sets a channel mask, picks an operating mode and arms or disarms conversion. The sequencer then hands channel numbers to the converter through a start/done handshake. It stores each 10-bit result in a per-channel data register and keeps a data-valid flag for every channel.

Three orderings are offered. In read-triggered mode, each host read of a data register launches a conversion on the next active channel. In single-scan mode, every active channel is converted once and the scan then raises an interrupt. In continuous mode, the active channels are swept without end until the host disarms the block. A scan may begin on a channel outside the mask. After the highest active channel it wraps to the lowest. A scan finishes when every active channel reports valid data, not after a fixed count.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset no conversion is running, `int_n` is high, `osc_en` is low, and the status register reads 0.
- R2: Register addresses are as follows. 0..7 are the channel data registers, with the result in bits 9:0. 8 is the mode register: bit 3 selects the internal clock, bit 2 enables the interrupt pin, and bits 1:0 hold the mode (1 read-triggered, 2 single scan, 3 continuous). 9 is the channel mask, with bit n for channel n. 10 is the start register: bit 4 arms, bit 3 loads the pointer, and bits 2:0 hold the channel. 11 is status: bit 0 interrupt, bit 1 all-converted, bit 2 in-progress, bits 5:3 pointer, bits 15:8 data-valid flags. A start write with bit 4 = 0 and bit 3 = 1 loads the pointer and launches nothing.
- R3: `conv_start` is a one-cycle pulse with `conv_ch` equal to the pointer. A `conv_done` received while waiting stores `conv_result` in that channel's data register and sets its data-valid flag. A `conv_done` at any other time is ignored.
- R4: In single-scan mode, arming converts the pointer channel first, even if it is not in the mask. It then proceeds upward through the active channels, wrapping from the highest to the lowest. The scan ends when the flags of all active channels are set. The pointer then rests on the next active channel after the last one converted.
- R5: The in-progress flag is high while a conversion is awaited in modes 1 and 2. It is low in the cycle each conversion is issued, so it drops between conversions. It reads 0 in continuous mode.
- R6: At the end of a single scan, the interrupt and all-converted flags are set, the block disarms, and `osc_en` falls. `int_n` goes low only when interrupt enable is set.
- R7: Start writes never clear data-valid flags. A single scan armed while all active flags are already set converts only the pointer channel.
- R8: A start write with bit 4 = 0 during a scan lets the running conversion complete and store its result. No further conversion follows.
- R9: Continuous mode wraps without end. All-converted is set after the first full pass. The interrupt flag stays clear and `int_n` stays high.
- R10: In read-triggered mode, arming converts the pointer channel. Each later data register read issued while idle converts the next active channel after the pointer. After each conversion the pointer equals the channel just converted.
- R11: Reading a data register clears that channel's data-valid flag. Writing the mask clears all data-valid flags.
- R12: Reading the status register clears the interrupt flag and releases `int_n`.
- R13: `abort_i` returns the block to idle and disarms it in the next cycle. The result of the abandoned conversion is not stored.
- R14: `osc_en` is high only when the internal clock is selected and the block is armed or converting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous abort |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | 3 | Channel to convert |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 10 | Converter result |
| int_n | output | 1 | Interrupt pin, active low |
| osc_en | output | 1 | Internal oscillator enable |

## Verification
On every cycle the assertions check the local rules of the handshake and the flags. The start pulse lasts one cycle, and a stored result sets its flag. The in-progress flag falls after each done. A stop lets no new start through, an abort empties the pipeline, and the pointer holds in read-triggered mode. Only the bench scenarios can show the global ordering: the scan sequence with an inactive first channel and wrap-around, and the termination caused by stale flags. They also cover the continuous pass count, the read-triggered chain, and the full status word after each mode.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH = 8,
  parameter int RW  = 10,
  parameter int DW  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          conv_start,
  output logic [2:0]    conv_ch,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_result,
  output logic          int_n,
  output logic          osc_en
);
  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT} state_t;
  localparam logic [1:0] M_READ = 2'd1, M_SINGLE = 2'd2, M_CONT = 2'd3;

  state_t         st;
  logic           enc, ie, csel, intf, acc;
  logic [1:0]     mode;
  logic [2:0]     ptr;
  logic [NCH-1:0] mask, dv;
  logic [RW-1:0]  dreg [NCH];

  function automatic logic [2:0] next_act(input logic [2:0] p, input logic [NCH-1:0] m);
    logic [2:0] c;
    next_act = p;
    for (int i = NCH - 1; i >= 1; i--) begin
      c = 3'((int'(p) + i) % NCH);
      if (m[c]) next_act = c;
    end
  endfunction

  wire            is_data = !reg_addr[3];
  wire [2:0]      rch     = reg_addr[2:0];
  wire            wr_mode = reg_wr && reg_addr == 4'h8;
  wire            wr_mask = reg_wr && reg_addr == 4'h9;
  wire            wr_go   = reg_wr && reg_addr == 4'hA;
  wire            rd_stat = reg_rd && reg_addr == 4'hB;
  wire            rd_data = reg_rd && is_data;
  wire            waiting = st == S_WAIT;
  wire            cip     = waiting && mode != M_CONT;
  wire [NCH-1:0]  pend    = mask & ~(dv | (NCH'(1) << ptr));
  wire [2:0]      nxt     = next_act(ptr, mask);
  wire            arm     = reg_wdata[4] && mode != 2'd0;

  assign conv_start = st == S_START;
  assign conv_ch    = ptr;
  assign int_n      = !(intf && ie && mode != M_CONT);
  assign osc_en     = csel && (enc || st != S_IDLE);

  always_comb begin
    reg_rdata = '0;
    if (is_data) reg_rdata[RW-1:0] = dreg[rch];
    else case (reg_addr[1:0])
      2'd0: reg_rdata[3:0] = {csel, ie, mode};
      2'd1: reg_rdata[NCH-1:0] = mask;
      2'd2: reg_rdata[4:0] = {enc, 1'b0, ptr};
      default: begin
        reg_rdata[2:0]      = {cip, acc, intf};
        reg_rdata[5:3]      = ptr;
        reg_rdata[8 +: NCH] = dv;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {enc, ie, csel, intf, acc} <= '0;
      mode <= '0;
      ptr  <= '0;
      mask <= '0;
      dv   <= '0;
      for (int i = 0; i < NCH; i++) dreg[i] <= '0;
    end else begin
      if (wr_mode) {csel, ie, mode} <= reg_wdata[3:0];
      if (wr_mask) begin
        mask <= reg_wdata[NCH-1:0];
        dv   <= '0;
      end
      if (rd_data) dv[rch] <= 1'b0;
      if (rd_stat) intf <= 1'b0;
      if (wr_go) enc <= arm;
      if (abort_i) begin
        st  <= S_IDLE;
        enc <= 1'b0;
      end else case (st)
        S_IDLE: begin
          if (wr_go && reg_wdata[3]) ptr <= reg_wdata[2:0];
          if (wr_go && arm) begin
            st  <= S_START;
            acc <= 1'b0;
          end else if (rd_data && enc && mode == M_READ) begin
            ptr <= nxt;
            st  <= S_START;
          end
        end
        S_START: st <= S_WAIT;
        default: if (conv_done) begin
          dreg[ptr] <= conv_result;
          dv[ptr]   <= 1'b1;
          if (mode != M_READ) ptr <= nxt;
          if (!enc || mode == M_READ) st <= S_IDLE;
          else if (mode == M_SINGLE && pend == '0) begin
            st   <= S_IDLE;
            enc  <= 1'b0;
            intf <= 1'b1;
            acc  <= 1'b1;
          end else begin
            st <= S_START;
            if (pend == '0) acc <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module adc_scan_seq_chk #(parameter int NCH = 8) (
  input logic           clk,
  input logic           rst_n,
  input logic           abort_i,
  input logic           conv_start,
  input logic           conv_done,
  input logic           waiting,
  input logic           cip,
  input logic           enc,
  input logic [1:0]     mode,
  input logic [2:0]     conv_ch,
  input logic [2:0]     ptr,
  input logic [NCH-1:0] dv
);
  p_start_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_dv_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && conv_done && !abort_i) |=> dv[$past(conv_ch)]);
  p_cip_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cip && conv_done) |=> !cip);
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && conv_done && !enc) |=> !conv_start);
  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && waiting && conv_done && !abort_i) |=> ptr == $past(ptr));
  p_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (!conv_start && !cip && !enc));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .conv_start(conv_start),
  .conv_done(conv_done), .waiting(waiting), .cip(cip), .enc(enc),
  .mode(mode), .conv_ch(conv_ch), .ptr(ptr), .dv(dv)
);

// File: tb/sim_adc_scan_seq.sv
module sim_adc_scan_seq;
  localparam int LAT = 3;

  logic        clk = 0, rst_n = 0, abort_i = 0, reg_wr = 0, reg_rd = 0, conv_done = 0;
  logic [3:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [9:0]  conv_result = 0;
  logic [15:0] reg_rdata;
  logic        conv_start, int_n, osc_en;
  logic [2:0]  conv_ch;
  int          n_run = 0, n_fail = 0, nstarts = 0, gen = 0;
  int          exp_q[$];
  logic [9:0]  model_res [8];

  always #5 clk = ~clk;

  adc_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_result(conv_result), .int_n(int_n), .osc_en(osc_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_ch(input int c);
    exp_q.push_back(c);
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  // converter model and scoreboard monitor
  initial begin
    int ch;
    for (int i = 0; i < 8; i++) model_res[i] = '0;
    forever begin
      @(negedge clk);
      conv_done = 0;
      if (conv_start) begin
        ch = int'(conv_ch);
        nstarts++;
        if (exp_q.size() == 0) check("R4 unexpected conversion start", ch, -1);
        else check("R4 scan order", ch, exp_q.pop_front());
        repeat (LAT) @(negedge clk);
        gen++;
        model_res[ch] = 10'((ch * 97 + gen * 13) & 1023);
        conv_result = model_res[ch];
        conv_done = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [9:0]  prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(4'hB, d);
    check("R1 status after reset", d, 0);
    check("R1 int_n after reset", int_n, 1);
    check("R1 osc_en after reset", osc_en, 0);
    check("R1 conv_start after reset", conv_start, 0);

    wr(4'hA, 8'h0D);
    repeat (5) @(negedge clk);
    peek(4'hB, d);
    check("R2 pointer load", d[5:3], 5);
    check("R2 pointer load starts nothing", nstarts, 0);

    // single scan from active channel 2, mask {1,2,5}
    wr(4'h8, 8'h0E);
    wr(4'h9, 8'h26);
    expect_ch(2); expect_ch(5); expect_ch(1);
    wr(4'hA, 8'h1A);
    wait (nstarts == 1);
    peek(4'hB, d);
    check("R5 cip low while issuing", d[2], 0);
    check("R14 osc_en on during scan", osc_en, 1);
    @(negedge clk);
    peek(4'hB, d);
    check("R5 cip high while waiting", d[2], 1);
    settle();
    check("R4 expected channels all seen", exp_q.size(), 0);
    check("R6 int_n low with interrupt enabled", int_n, 0);
    check("R14 osc_en off after scan", osc_en, 0);
    peek(4'hB, d);
    check("R6 status after single scan", d, 16'h2613);
    peek(4'h1, d); check("R3 result ch1", d[9:0], model_res[1]);
    peek(4'h2, d); check("R3 result ch2", d[9:0], model_res[2]);
    peek(4'h5, d); check("R3 result ch5", d[9:0], model_res[5]);
    rd(4'hB, d);
    check("R12 int_n released by status read", int_n, 1);
    peek(4'hB, d);
    check("R12 interrupt flag cleared", d[0], 0);

    // single scan from inactive channel 0, interrupt disabled
    wr(4'h8, 8'h0A);
    wr(4'h9, 8'h24);
    expect_ch(0); expect_ch(2); expect_ch(5);
    wr(4'hA, 8'h18);
    settle();
    check("R4 inactive start channels seen", exp_q.size(), 0);
    peek(4'hB, d);
    check("R4 status after inactive start and wrap", d, 16'h2513);
    check("R6 int_n high without interrupt enable", int_n, 1);

    // stale flags
    expect_ch(2);
    wr(4'hA, 8'h10);
    settle();
    check("R7 stale flags stop scan after one conversion", nstarts, 7);
    peek(4'hB, d);
    check("R7 status after stale scan", d, 16'h252B);

    rd(4'h5, d);
    check("R11 data read value", d[9:0], model_res[5]);
    peek(4'hB, d);
    check("R11 data read clears its flag", d[15:8], 8'h05);
    wr(4'h9, 8'h24);
    peek(4'hB, d);
    check("R11 mask write clears all flags", d[15:8], 0);
    rd(4'hB, d);

    // continuous scan mask {0,7}, then stop
    wr(4'h8, 8'h0F);
    wr(4'h9, 8'h81);
    expect_ch(0); expect_ch(7); expect_ch(0);
    wr(4'hA, 8'h18);
    wait (nstarts == 8);
    @(negedge clk);
    peek(4'hB, d);
    check("R5 cip zero in continuous mode", d[2], 0);
    wait (nstarts == 10);
    peek(4'hB, d);
    check("R9 all-converted after first pass", d[1], 1);
    check("R9 interrupt flag stays clear", d[0], 0);
    check("R9 int_n high in continuous mode", int_n, 1);
    @(negedge clk);
    wr(4'hA, 8'h00);
    settle();
    check("R8 no start after stop", nstarts, 10);
    check("R8 scoreboard drained", exp_q.size(), 0);
    peek(4'h0, d);
    check("R8 running conversion stored", d[9:0], model_res[0]);
    check("R14 osc_en off after stop", osc_en, 0);
    peek(4'hB, d);
    check("R9 status after continuous stop", d, 16'h813A);

    // read-triggered mode, mask {2,3}
    wr(4'h8, 8'h01);
    wr(4'h9, 8'h0C);
    expect_ch(3);
    wr(4'hA, 8'h1B);
    settle();
    peek(4'hB, d);
    check("R10 pointer equals converted channel", d[5:3], 3);
    check("R10 flag of converted channel", d[15:8], 8'h08);
    check("R14 osc_en low without internal clock", osc_en, 0);
    expect_ch(2);
    rd(4'h3, d);
    check("R10 data read value", d[9:0], model_res[3]);
    settle();
    check("R10 read launches next active channel", nstarts, 12);
    peek(4'hB, d);
    check("R10 status after triggered conversion", d, 16'h0410);
    wr(4'hA, 8'h00);

    // abort
    wr(4'h8, 8'h0A);
    wr(4'h9, 8'hFF);
    prev = model_res[0];
    expect_ch(0);
    wr(4'hA, 8'h18);
    wait (nstarts == 13);
    @(negedge clk);
    abort_i = 1;
    @(negedge clk);
    abort_i = 0;
    settle();
    check("R13 no start after abort", nstarts, 13);
    check("R13 scoreboard drained", exp_q.size(), 0);
    peek(4'h0, d);
    check("R13 abandoned result not stored", d[9:0], prev);
    peek(4'hB, d);
    check("R13 status idle after abort", d, 0);
    check("R13 osc_en off after abort", osc_en, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule